// File: doc/BRIEF.md
# Mode-Dependent Video Address Generator

This block is the address side of a raster refresh engine for a 200-line display. It walks the screen one byte per clock and gives the video RAM a 14-bit byte address. It also gives a scan-line index to the glyph or pixel path, a flag telling the first byte of a fetch pair from the second, display-enable, and a one-cycle frame-start pulse. Horizontal and vertical blanking lengths are parameters. Sync pulse widths, the RAM, the glyph ROM and the pixel shifter are outside the block.

Two counting patterns are available. Character mode has 25 rows of 80 cells. Each cell is a pair of bytes: the glyph code at the even address and the attribute at the odd address. Each row of cells is replayed for eight scan lines. Bitmap mode has 100 address rows of 40 byte pairs, and each row is used for two scan lines. On bitmap lines, the low bit of the scan counter becomes address bit 13, so odd lines read from the upper 8 KB bank. The mode input is sampled only at a frame boundary. The separate mode bit that picks the pixel output path is not part of this block.

Top module: `video_addr_gen`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, the outputs show the frame origin in character mode: frame_start_o=1, de_o=1, addr_o=0, scan_o=0, bsel_o=0.
- R2: In character mode, visible byte k (0..159) of a line in character row r gives addr_o = 160*r + k. Even addresses are glyph bytes and odd addresses are attribute bytes. bsel_o is the low bit of addr_o in both modes (0 = first byte of the pair).
- R3: In character mode, a line numbered L lies in character row L/8, and scan_o = L mod 8. The same 160 addresses repeat on all eight lines of a row.
- R4: In character mode, the last visible byte of the frame (line 199, byte 159) has address 3999.
- R5: In bitmap mode, visible byte k (0..79) of line L gives addr_o = 8192*(L mod 2) + 80*(L/2) + k, and scan_o = L mod 2.
- R6: In bitmap mode, the last visible byte of the frame (line 199, byte 79) has address 16191.
- R7: Each line has its visible bytes (160 in character mode, 80 in bitmap mode) followed by H_BLANK cycles with de_o=0. The frame has 200 visible lines followed by V_BLANK lines with de_o=0.
- R8: While de_o=0, addr_o and bsel_o keep the values of the last visible byte.
- R9: frame_start_o is high for exactly one cycle per frame, on the first visible byte, where addr_o=0. With the default parameters, a bitmap frame lasts 204*96 = 19584 cycles.
- R10: mode_i (0 = character, 1 = bitmap) is sampled only on the clock edge that ends a frame. A change in the middle of a frame has no effect until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Requested pattern: 0 character, 1 bitmap |
| addr_o | output | 14 | Video RAM byte address |
| bsel_o | output | 1 | Byte of the fetch pair (0 first, 1 second) |
| scan_o | output | SCAN_W (3) | Scan line within the character row or bitmap line pair |
| de_o | output | 1 | Display enable |
| frame_start_o | output | 1 | One-cycle pulse on the first byte of a frame |

## Verification
The bench probes row boundaries where a design could get the replay count wrong. A design that advances the row base every line, or after the wrong number of lines, shows the wrong address on line 8 in character mode or on line 2 in bitmap mode. The bench reads odd bitmap lines to catch a missing or misplaced bank bit, which would put the odd lines into the lower 8 KB. It reads blanking cycles, where an unheld address would fall to zero or run past the row. It changes the mode in the middle of a frame, where a design that samples the mode at once would jump to the other address pattern in the following line.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic {
    VM_TEXT = 1'b0,
    VM_GFX  = 1'b1
  } vmode_e;

  localparam int unsigned ADDR_W = 14;
  localparam int unsigned LIN_W  = ADDR_W - 1;
endpackage

// File: rtl/vag_hcount.sv
module vag_hcount import vag_pkg::*; #(
  parameter int unsigned TEXT_COLS = 80,
  parameter int unsigned GFX_COLS  = 40,
  parameter int unsigned H_BLANK   = 16,
  parameter int unsigned HPOS_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  vmode_e            mode_i,
  output logic [HPOS_W-1:0] hpos_o,
  output logic              h_vis_o,
  output logic              hpos_zero_o,
  output logic              line_end_o
);
  localparam logic [HPOS_W-1:0] TEXT_VIS = HPOS_W'(2 * TEXT_COLS);
  localparam logic [HPOS_W-1:0] GFX_VIS  = HPOS_W'(2 * GFX_COLS);
  localparam logic [HPOS_W-1:0] HB_LEN   = HPOS_W'(H_BLANK);

  logic [HPOS_W-1:0] hpos_q, vis_len, last_pos;

  always_comb begin
    vis_len  = (mode_i == VM_GFX) ? GFX_VIS : TEXT_VIS;
    last_pos = vis_len + HB_LEN - HPOS_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hpos_q <= '0;
    else if (line_end_o) hpos_q <= '0;
    else                 hpos_q <= hpos_q + HPOS_W'(1);
  end

  assign hpos_o      = hpos_q;
  assign h_vis_o     = hpos_q < vis_len;
  assign hpos_zero_o = hpos_q == '0;
  assign line_end_o  = hpos_q == last_pos;

  AST_HPOS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpos_q <= last_pos); // R7
endmodule

// File: rtl/vag_vcount.sv
module vag_vcount import vag_pkg::*; #(
  parameter int unsigned TEXT_COLS = 80,
  parameter int unsigned GFX_COLS  = 40,
  parameter int unsigned TEXT_SCAN = 8,
  parameter int unsigned GFX_SCAN  = 2,
  parameter int unsigned VIS_LINES = 200,
  parameter int unsigned V_BLANK   = 4,
  parameter int unsigned LINE_W    = 8,
  parameter int unsigned SCAN_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  vmode_e            mode_req_i,
  input  logic              hpos_zero_i,
  input  logic              line_end_i,
  output vmode_e            mode_o,
  output logic              v_vis_o,
  output logic              frame_start_o,
  output logic [SCAN_W-1:0] scan_o,
  output logic [LIN_W-1:0]  base_o
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(VIS_LINES + V_BLANK - 1);
  localparam logic [LINE_W-1:0] VIS_LEN   = LINE_W'(VIS_LINES);
  localparam logic [LIN_W-1:0]  TEXT_STEP = LIN_W'(2 * TEXT_COLS);
  localparam logic [LIN_W-1:0]  GFX_STEP  = LIN_W'(2 * GFX_COLS);
  localparam logic [SCAN_W-1:0] TEXT_LAST = SCAN_W'(TEXT_SCAN - 1);
  localparam logic [SCAN_W-1:0] GFX_LAST  = SCAN_W'(GFX_SCAN - 1);

  logic [LINE_W-1:0] line_q;
  logic [SCAN_W-1:0] scan_q, scan_last;
  logic [LIN_W-1:0]  base_q, row_step;
  vmode_e            mode_q;
  logic              frame_end;

  always_comb begin
    scan_last = (mode_q == VM_GFX) ? GFX_LAST : TEXT_LAST;
    row_step  = (mode_q == VM_GFX) ? GFX_STEP : TEXT_STEP;
    frame_end = line_end_i && (line_q == LAST_LINE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      scan_q <= '0;
      base_q <= '0;
      mode_q <= VM_TEXT;
    end else if (frame_end) begin
      line_q <= '0;
      scan_q <= '0;
      base_q <= '0;
      mode_q <= mode_req_i;  // pattern switches only here
    end else if (line_end_i) begin
      line_q <= line_q + LINE_W'(1);
      if (line_q < VIS_LEN) begin
        if (scan_q == scan_last) begin
          scan_q <= '0;
          base_q <= base_q + row_step;
        end else begin
          scan_q <= scan_q + SCAN_W'(1);
        end
      end
    end
  end

  assign mode_o        = mode_q;
  assign v_vis_o       = line_q < VIS_LEN;
  assign frame_start_o = (line_q == '0) && hpos_zero_i;
  assign scan_o        = scan_q;
  assign base_o        = base_q;

  AST_FS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o); // R9
  AST_MODE_FRAME_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(mode_q)); // R10
  AST_SCAN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_vis_o |-> scan_q <= scan_last); // R3
endmodule

// File: rtl/vag_addr.sv
module vag_addr import vag_pkg::*; #(
  parameter int unsigned HPOS_W     = 8,
  parameter int unsigned SCAN_W     = 3,
  parameter int unsigned TEXT_BYTES = 4000,
  parameter int unsigned GFX_BYTES  = 8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  vmode_e            mode_i,
  input  logic              de_i,
  input  logic [LIN_W-1:0]  base_i,
  input  logic [HPOS_W-1:0] hpos_i,
  input  logic [SCAN_W-1:0] scan_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bsel_o
);
  logic [LIN_W-1:0]  lin;
  logic [ADDR_W-1:0] cur_addr, addr_q;

  always_comb begin
    lin = base_i + LIN_W'(hpos_i);
    // bitmap: scan LSB lands on the top address bit -> 8 KB bank per odd line
    cur_addr = (mode_i == VM_GFX) ? {scan_i[0], lin} : {1'b0, lin};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (de_i) addr_q <= cur_addr;
  end

  assign addr_o = de_i ? cur_addr : addr_q;
  assign bsel_o = addr_o[0];

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_i |-> $stable(addr_o)); // R8
  AST_TEXT_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_i && mode_i == VM_TEXT) |-> addr_o < ADDR_W'(TEXT_BYTES)); // R4
  AST_GFX_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_i && mode_i == VM_GFX) |-> addr_o[LIN_W-1:0] < LIN_W'(GFX_BYTES)); // R6
endmodule

// File: rtl/video_addr_gen.sv
module video_addr_gen import vag_pkg::*; #(
  parameter int unsigned TEXT_COLS = 80,
  parameter int unsigned GFX_COLS  = 40,
  parameter int unsigned TEXT_SCAN = 8,
  parameter int unsigned GFX_SCAN  = 2,
  parameter int unsigned VIS_LINES = 200,
  parameter int unsigned H_BLANK   = 16,
  parameter int unsigned V_BLANK   = 4,
  localparam int unsigned SCAN_W   = (TEXT_SCAN > 1) ? $clog2(TEXT_SCAN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bsel_o,
  output logic [SCAN_W-1:0] scan_o,
  output logic              de_o,
  output logic              frame_start_o
);
  localparam int unsigned HPOS_W     = $clog2(2 * TEXT_COLS + H_BLANK);
  localparam int unsigned LINE_W     = $clog2(VIS_LINES + V_BLANK);
  localparam int unsigned TEXT_BYTES = 2 * TEXT_COLS * (VIS_LINES / TEXT_SCAN);
  localparam int unsigned GFX_BYTES  = 2 * GFX_COLS * (VIS_LINES / GFX_SCAN);

  vmode_e            mode_act;
  logic [HPOS_W-1:0] hpos;
  logic              h_vis, hpos_zero, line_end, v_vis;
  logic [LIN_W-1:0]  base;

  vag_hcount #(
    .TEXT_COLS(TEXT_COLS), .GFX_COLS(GFX_COLS), .H_BLANK(H_BLANK), .HPOS_W(HPOS_W)
  ) u_hcount (
    .clk_i, .rst_ni, .mode_i(mode_act), .hpos_o(hpos), .h_vis_o(h_vis),
    .hpos_zero_o(hpos_zero), .line_end_o(line_end)
  );

  vag_vcount #(
    .TEXT_COLS(TEXT_COLS), .GFX_COLS(GFX_COLS), .TEXT_SCAN(TEXT_SCAN), .GFX_SCAN(GFX_SCAN),
    .VIS_LINES(VIS_LINES), .V_BLANK(V_BLANK), .LINE_W(LINE_W), .SCAN_W(SCAN_W)
  ) u_vcount (
    .clk_i, .rst_ni, .mode_req_i(vmode_e'(mode_i)), .hpos_zero_i(hpos_zero),
    .line_end_i(line_end), .mode_o(mode_act), .v_vis_o(v_vis),
    .frame_start_o(frame_start_o), .scan_o(scan_o), .base_o(base)
  );

  assign de_o = h_vis && v_vis;

  vag_addr #(
    .HPOS_W(HPOS_W), .SCAN_W(SCAN_W), .TEXT_BYTES(TEXT_BYTES), .GFX_BYTES(GFX_BYTES)
  ) u_addr (
    .clk_i, .rst_ni, .mode_i(mode_act), .de_i(de_o), .base_i(base), .hpos_i(hpos),
    .scan_i(scan_o), .addr_o(addr_o), .bsel_o(bsel_o)
  );
endmodule

// File: tb/tb_video_addr_gen.sv
module tb_video_addr_gen;
  localparam int LEN_T = 176;
  localparam int LEN_G = 96;
  localparam int WATCHDOG = 190000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic [13:0] addr_o;
  logic        bsel_o;
  logic [2:0]  scan_o;
  logic        de_o;
  logic        frame_start_o;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int cur_t = 0;
  logic cur_mode = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  video_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .addr_o(addr_o), .bsel_o(bsel_o),
    .scan_o(scan_o), .de_o(de_o), .frame_start_o(frame_start_o)
  );

  typedef struct packed {
    logic        m;
    logic [7:0]  ln;
    logic [7:0]  k;
    logic [13:0] addr;
    logic [2:0]  scan;
    logic        de;
    logic        fs;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,   8'd0,   14'd0,     3'd0, 1'b1, 1'b1, 4'd2},  // R2
    '{1'b0, 8'd0,   8'd1,   14'd1,     3'd0, 1'b1, 1'b0, 4'd2},  // R2
    '{1'b0, 8'd0,   8'd159, 14'd159,   3'd0, 1'b1, 1'b0, 4'd2},  // R2
    '{1'b0, 8'd0,   8'd160, 14'd159,   3'd0, 1'b0, 1'b0, 4'd8},  // R8
    '{1'b0, 8'd3,   8'd5,   14'd5,     3'd3, 1'b1, 1'b0, 4'd3},  // R3
    '{1'b0, 8'd7,   8'd100, 14'd100,   3'd7, 1'b1, 1'b0, 4'd3},  // R3
    '{1'b0, 8'd8,   8'd0,   14'd160,   3'd0, 1'b1, 1'b0, 4'd3},  // R3
    '{1'b0, 8'd8,   8'd37,  14'd197,   3'd0, 1'b1, 1'b0, 4'd2},  // R2
    '{1'b0, 8'd17,  8'd3,   14'd323,   3'd1, 1'b1, 1'b0, 4'd3},  // R3
    '{1'b0, 8'd199, 8'd159, 14'd3999,  3'd7, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b0, 8'd200, 8'd0,   14'd3999,  3'd0, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b1, 8'd0,   8'd0,   14'd0,     3'd0, 1'b1, 1'b1, 4'd5},  // R5
    '{1'b1, 8'd0,   8'd79,  14'd79,    3'd0, 1'b1, 1'b0, 4'd5},  // R5
    '{1'b1, 8'd0,   8'd80,  14'd79,    3'd0, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b1, 8'd1,   8'd0,   14'd8192,  3'd1, 1'b1, 1'b0, 4'd5},  // R5
    '{1'b1, 8'd1,   8'd45,  14'd8237,  3'd1, 1'b1, 1'b0, 4'd5},  // R5
    '{1'b1, 8'd2,   8'd0,   14'd80,    3'd0, 1'b1, 1'b0, 4'd5},  // R5
    '{1'b1, 8'd3,   8'd10,  14'd8282,  3'd1, 1'b1, 1'b0, 4'd5},  // R5
    '{1'b1, 8'd198, 8'd0,   14'd7920,  3'd0, 1'b1, 1'b0, 4'd5},  // R5
    '{1'b1, 8'd199, 8'd79,  14'd16191, 3'd1, 1'b1, 1'b0, 4'd6},  // R6
    '{1'b1, 8'd201, 8'd50,  14'd16191, 3'd0, 1'b0, 1'b0, 4'd8}   // R8
  };

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      total++;
      fails++;
      $display("FAIL R7 watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic wait_fs();
    @(negedge clk);
    while (!frame_start_o) @(negedge clk);
    cur_t = 0;
  endtask

  task automatic seek(input logic m, input int ln, input int k);
    int tgt;
    tgt = ln * (m ? LEN_G : LEN_T) + k;
    if (m != cur_mode || tgt < cur_t) begin
      mode_i = m;
      wait_fs();
      cur_mode = m;
    end
    while (cur_t < tgt) begin
      @(negedge clk);
      cur_t++;
    end
  endtask

  initial begin
    int n;
    mode_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "fs in reset", int'(frame_start_o), 1);
    chk("R1", "addr in reset", int'(addr_o), 0);
    rst_ni = 1'b1;
    // first cycle after release
    chk("R1", "fs", int'(frame_start_o), 1);
    chk("R1", "de", int'(de_o), 1);
    chk("R1", "addr", int'(addr_o), 0);
    chk("R1", "scan", int'(scan_o), 0);
    chk("R1", "bsel", int'(bsel_o), 0);
    cur_t = 0;
    cur_mode = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].rq);
      seek(VECS[i].m, int'(VECS[i].ln), int'(VECS[i].k));
      chk(rq, "addr", int'(addr_o), int'(VECS[i].addr));
      chk(rq, "bsel", int'(bsel_o), int'(VECS[i].addr[0]));
      chk(rq, "de", int'(de_o), int'(VECS[i].de));
      chk(rq, "fs", int'(frame_start_o), int'(VECS[i].fs));
      if (VECS[i].de) chk(rq, "scan", int'(scan_o), int'(VECS[i].scan));
    end

    // R9: single-cycle pulse and bitmap frame period
    wait_fs();
    @(negedge clk);
    chk("R9", "fs width", int'(frame_start_o), 0);
    n = 1;
    while (!frame_start_o) begin
      @(negedge clk);
      n++;
    end
    chk("R9", "frame period", n, 19584);
    cur_t = 0;
    cur_mode = 1'b1;

    // R10: request character mode mid bitmap frame
    seek(1'b1, 50, 0);
    mode_i = 1'b0;
    repeat (LEN_G) @(negedge clk);
    chk("R10", "addr after mid-frame change", int'(addr_o), 10192);
    chk("R10", "scan after mid-frame change", int'(scan_o), 1);
    wait_fs();
    cur_mode = 1'b0;
    seek(1'b0, 8, 0);
    chk("R10", "addr in next frame", int'(addr_o), 160);
    chk("R10", "scan in next frame", int'(scan_o), 0);

    summary();
    $finish;
  end
endmodule